// File: doc/BRIEF.md
# Smart card deactivation sequencer

This block switches off the contacts of a smart card slot in a fixed order. It has two jobs. While a card session runs, it holds the card reset, clock gate, I/O enable and supply enable high. When the host raises its power-off command, or when any hardware fault input goes high, it lowers those four outputs one after another. Each step takes its own programmable number of clock cycles. It then waits for the card supply to discharge before it reports that the sequence is complete.

The block is clocked by the 1.5 MHz timing oscillator, so each step length is a cycle count. The default lengths are 1, 12, 1 and 1 cycles, which meet minimum gaps of 0.5 µs, 7.5 µs, 0.5 µs and 0.5 µs with margin. The default discharge timeout of 120 cycles keeps the whole shutdown under 100 µs. The fault inputs are synchronous digital levels:

- over-current
- over-temperature
- logic supply fault
- one combined input that goes high when the converter output falls below the card supply
- card removal

The fault inputs that caused a shutdown are held in a cause register. A new session starts only after the host has raised its command again and then lowered it, and only while no fault input is high.

Top module: `sc_deact_seq`

## Requirements
- R1: After reset, all four contact enables and the busy flag are low, the done flag is high and the fault cause is zero.
- R2: In the off state, the cycle after the host command is sampled low with no fault input high, all four contact enables rise together and the done flag falls. This applies only if the command was seen high after the last deactivation or reset.
- R3: During a session, a sampled high host command or any sampled high fault input raises the busy flag on the next cycle.
- R4: The card reset falls T_RST_CYC cycles after busy rises. The clock enable falls T_CLK_CYC cycles after that, the I/O enable falls T_IO_CYC cycles after that, and the supply enable falls T_VCC_CYC cycles after that. At no time is a later-step output low while an earlier-step output is high.
- R5: flt_cause_o records the fault inputs that were high in the triggering cycle. The bit positions are: 0 over-current, 1 over-temperature, 2 logic supply, 3 combined converter/card supply, 4 card removal. The register keeps its value through the sequence and clears when the next session starts. Faults that arrive while the sequence runs are not recorded.
- R6: Once busy has risen, the sequence runs to completion with unchanged step timing. This holds if the trigger is withdrawn and if new triggers arrive.
- R7: Busy falls and done rises together. This happens one cycle after the supply enable falls if supply_low_i is high, or DISCH_CYC cycles after it falls if supply_low_i stays low.
- R8: While off, no activation occurs if the host command has not been high since the last shutdown, or while any fault input is high.
- R9: A host command and a fault sampled in the same cycle start one sequence with the R4 timing, and the fault is recorded as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock (1.5 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_off_i | input | 1 | Host power command, high = off request |
| ovc_flt_i | input | 1 | Over-current fault level |
| ovt_flt_i | input | 1 | Over-temperature fault level |
| vdd_flt_i | input | 1 | Logic supply fault level |
| vsup_flt_i | input | 1 | Combined converter/card supply fault level |
| card_gone_i | input | 1 | Card removal, high = no card |
| supply_low_i | input | 1 | Card supply has discharged |
| card_rst_o | output | 1 | Card reset line, high = released |
| card_clk_en_o | output | 1 | Card clock gate, low forces clock low |
| card_io_en_o | output | 1 | I/O enable, low drives I/O low and leaves reception |
| card_vcc_en_o | output | 1 | Card supply enable |
| deact_busy_o | output | 1 | Deactivation under way |
| deact_done_o | output | 1 | Card fully off |
| flt_cause_o | output | 5 | Latched fault cause, positions per R5 |

## Verification
The host power-off command and a fault can be sampled in the same cycle. The bench provokes this by raising the command and pulsing the over-temperature input on the same falling edge. The scoreboard then has to see exactly one busy rise and the R4 step edges at their computed cycles, and the cause register has to hold only the over-temperature bit. The same scoreboard also covers a fault pulse that lands mid-sequence: the timing must not move and the cause must stay zero.

// File: rtl/sc_deact_pkg.sv
package sc_deact_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_RST_W,
    ST_CLK_W,
    ST_IO_W,
    ST_VCC_W,
    ST_DISCH,
    ST_DONE
  } seq_state_e;

  localparam int FLT_N    = 5;
  localparam int FLT_OVC  = 0;
  localparam int FLT_OVT  = 1;
  localparam int FLT_VDD  = 2;
  localparam int FLT_VSUP = 3;
  localparam int FLT_CARD = 4;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sc_step_timer.sv
module sc_step_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sc_flt_latch.sv
module sc_flt_latch #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flt_i,
  input  logic         arm_i,
  input  logic         clr_i,
  output logic [N-1:0] lat_o,
  output logic         any_o
);

  logic [N-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (clr_i)  lat_q <= '0;
    else if (arm_i)  lat_q <= lat_q | flt_i;
  end

  assign lat_o = lat_q;
  assign any_o = |flt_i;

  // R5
  cause_arm_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lat_q & ~$past(lat_q))) |-> $past(arm_i));

  // R5
  cause_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (lat_q == '0));

endmodule

// File: rtl/sc_deact_ctrl.sv
module sc_deact_ctrl
  import sc_deact_pkg::*;
#(
  parameter int T_RST_CYC      = 1,
  parameter int T_CLK_CYC      = 12,
  parameter int T_IO_CYC       = 1,
  parameter int T_VCC_CYC      = 1,
  parameter int DISCH_CYC      = 120,
  parameter bit USE_SUPPLY_LOW = 1'b1,
  parameter int W              = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_off_i,
  input  logic         flt_any_i,
  input  logic         supply_low_i,
  input  logic         tmr_zero_i,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output logic         arm_o,
  output logic         clr_o,
  output logic         card_rst_o,
  output logic         clk_en_o,
  output logic         io_en_o,
  output logic         vcc_en_o,
  output logic         busy_o,
  output logic         done_o
);

  localparam logic [W-1:0] L_RST = W'(T_RST_CYC - 1);
  localparam logic [W-1:0] L_CLK = W'(T_CLK_CYC - 1);
  localparam logic [W-1:0] L_IO  = W'(T_IO_CYC - 1);
  localparam logic [W-1:0] L_VCC = W'(T_VCC_CYC - 1);
  localparam logic [W-1:0] L_DIS = W'(DISCH_CYC - 1);

  seq_state_e state_q, state_d;
  logic       disch_end;

  generate
    if (USE_SUPPLY_LOW) begin : g_sense
      assign disch_end = supply_low_i | tmr_zero_i;
    end else begin : g_timed
      assign disch_end = tmr_zero_i;
    end
  endgenerate

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    clr_o      = 1'b0;
    unique case (state_q)
      ST_DONE:   if (cmd_off_i) state_d = ST_IDLE;
      ST_IDLE:   if (!cmd_off_i && !flt_any_i) begin
                   state_d = ST_ACTIVE;
                   clr_o   = 1'b1;
                 end
      ST_ACTIVE: if (cmd_off_i || flt_any_i) begin
                   state_d    = ST_RST_W;
                   tmr_load_o = 1'b1;
                   tmr_val_o  = L_RST;
                 end
      ST_RST_W:  if (tmr_zero_i) begin
                   state_d    = ST_CLK_W;
                   tmr_load_o = 1'b1;
                   tmr_val_o  = L_CLK;
                 end
      ST_CLK_W:  if (tmr_zero_i) begin
                   state_d    = ST_IO_W;
                   tmr_load_o = 1'b1;
                   tmr_val_o  = L_IO;
                 end
      ST_IO_W:   if (tmr_zero_i) begin
                   state_d    = ST_VCC_W;
                   tmr_load_o = 1'b1;
                   tmr_val_o  = L_VCC;
                 end
      ST_VCC_W:  if (tmr_zero_i) begin
                   state_d    = ST_DISCH;
                   tmr_load_o = 1'b1;
                   tmr_val_o  = L_DIS;
                 end
      ST_DISCH:  if (disch_end) state_d = ST_DONE;
      default:   state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_DONE;
    else         state_q <= state_d;
  end

  assign arm_o      = (state_q == ST_ACTIVE);
  assign card_rst_o = (state_q == ST_ACTIVE) || (state_q == ST_RST_W);
  assign clk_en_o   = card_rst_o || (state_q == ST_CLK_W);
  assign io_en_o    = clk_en_o   || (state_q == ST_IO_W);
  assign vcc_en_o   = io_en_o    || (state_q == ST_VCC_W);
  assign busy_o     = (state_q == ST_RST_W) || (state_q == ST_CLK_W) ||
                      (state_q == ST_IO_W)  || (state_q == ST_VCC_W) ||
                      (state_q == ST_DISCH);
  assign done_o     = (state_q == ST_DONE) || (state_q == ST_IDLE);

  // R8
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_DONE) |-> (state_q != ST_ACTIVE));

endmodule

// File: rtl/sc_deact_seq.sv
module sc_deact_seq
  import sc_deact_pkg::*;
#(
  parameter int T_RST_CYC      = 1,
  parameter int T_CLK_CYC      = 12,
  parameter int T_IO_CYC       = 1,
  parameter int T_VCC_CYC      = 1,
  parameter int DISCH_CYC      = 120,
  parameter bit USE_SUPPLY_LOW = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_off_i,
  input  logic       ovc_flt_i,
  input  logic       ovt_flt_i,
  input  logic       vdd_flt_i,
  input  logic       vsup_flt_i,
  input  logic       card_gone_i,
  input  logic       supply_low_i,
  output logic       card_rst_o,
  output logic       card_clk_en_o,
  output logic       card_io_en_o,
  output logic       card_vcc_en_o,
  output logic       deact_busy_o,
  output logic       deact_done_o,
  output logic [4:0] flt_cause_o
);

  localparam int MAX_CYC = max_of(max_of(max_of(T_RST_CYC, T_CLK_CYC),
                                         max_of(T_IO_CYC, T_VCC_CYC)), DISCH_CYC);
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam int SEQ_TOT = T_RST_CYC + T_CLK_CYC + T_IO_CYC + T_VCC_CYC + DISCH_CYC;
  localparam int SEQ_W   = $clog2(SEQ_TOT + 2);
  localparam logic [SEQ_W-1:0] AT_RST = SEQ_W'(T_RST_CYC);
  localparam logic [SEQ_W-1:0] AT_CLK = SEQ_W'(T_RST_CYC + T_CLK_CYC);
  localparam logic [SEQ_W-1:0] AT_IO  = SEQ_W'(T_RST_CYC + T_CLK_CYC + T_IO_CYC);
  localparam logic [SEQ_W-1:0] AT_VCC = SEQ_W'(T_RST_CYC + T_CLK_CYC + T_IO_CYC + T_VCC_CYC);

  logic [FLT_N-1:0] flt_vec;
  logic             flt_any, arm, clr, tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  assign flt_vec[FLT_OVC]  = ovc_flt_i;
  assign flt_vec[FLT_OVT]  = ovt_flt_i;
  assign flt_vec[FLT_VDD]  = vdd_flt_i;
  assign flt_vec[FLT_VSUP] = vsup_flt_i;
  assign flt_vec[FLT_CARD] = card_gone_i;

  sc_flt_latch #(.N(FLT_N)) u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flt_i  (flt_vec),
    .arm_i  (arm),
    .clr_i  (clr),
    .lat_o  (flt_cause_o),
    .any_o  (flt_any)
  );

  sc_step_timer #(.W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sc_deact_ctrl #(
    .T_RST_CYC      (T_RST_CYC),
    .T_CLK_CYC      (T_CLK_CYC),
    .T_IO_CYC       (T_IO_CYC),
    .T_VCC_CYC      (T_VCC_CYC),
    .DISCH_CYC      (DISCH_CYC),
    .USE_SUPPLY_LOW (USE_SUPPLY_LOW),
    .W              (TMR_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_off_i    (cmd_off_i),
    .flt_any_i    (flt_any),
    .supply_low_i (supply_low_i),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .arm_o        (arm),
    .clr_o        (clr),
    .card_rst_o   (card_rst_o),
    .clk_en_o     (card_clk_en_o),
    .io_en_o      (card_io_en_o),
    .vcc_en_o     (card_vcc_en_o),
    .busy_o       (deact_busy_o),
    .done_o       (deact_done_o)
  );

  // cycles since busy rose, used only by the gap checks
  logic [SEQ_W-1:0] seq_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seq_cnt_q <= '0;
    else if (deact_busy_o) seq_cnt_q <= seq_cnt_q + 1'b1;
    else                   seq_cnt_q <= '0;
  end

  // R4
  step_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_rst_o -> card_clk_en_o) && (card_clk_en_o -> card_io_en_o) &&
    (card_io_en_o -> card_vcc_en_o));

  // R4
  rst_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_rst_o) |-> (seq_cnt_q == AT_RST));

  // R4
  clk_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_clk_en_o) |-> (seq_cnt_q == AT_CLK));

  // R4
  io_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_io_en_o) |-> (seq_cnt_q == AT_IO));

  // R4
  vcc_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_vcc_en_o) |-> (seq_cnt_q == AT_VCC));

  // R3
  trigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_vcc_en_o && !deact_busy_o && (cmd_off_i || (|flt_vec))) |=> deact_busy_o);

  // R6
  run_to_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_busy_o |=> (deact_busy_o || deact_done_o));

  // R2
  act_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_vcc_en_o) |-> $past(!cmd_off_i && (flt_vec == '0)));

  // R7
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(deact_busy_o && deact_done_o));

endmodule

// File: tb/tb_sc_deact_seq.sv
module tb_sc_deact_seq;

  localparam int T1  = 2;
  localparam int T2  = 12;
  localparam int T3  = 1;
  localparam int T4  = 3;
  localparam int DIS = 20;
  localparam int WDOG = 20000;

  // event codes, also the order events are pushed within one cycle
  localparam int EV_DONE_F = 0, EV_VCC_R = 1, EV_IO_R = 2, EV_CLK_R = 3,
                 EV_RST_R = 4, EV_BUSY_R = 5, EV_RST_F = 6, EV_CLK_F = 7,
                 EV_IO_F = 8, EV_VCC_F = 9, EV_BUSY_F = 10, EV_DONE_R = 11;

  typedef struct {
    int     code;
    longint cyc;
    string  req;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd = 1'b0;
  logic [4:0] flt = '0;
  logic sl_en = 1'b1;
  logic supply_low;
  logic rst_o, clk_en, io_en, vcc_en, busy, done;
  logic [4:0] cause;
  longint cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  ev_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign supply_low = sl_en & ~vcc_en;

  sc_deact_seq #(
    .T_RST_CYC(T1), .T_CLK_CYC(T2), .T_IO_CYC(T3), .T_VCC_CYC(T4),
    .DISCH_CYC(DIS), .USE_SUPPLY_LOW(1'b1)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_off_i(cmd),
    .ovc_flt_i(flt[0]), .ovt_flt_i(flt[1]), .vdd_flt_i(flt[2]),
    .vsup_flt_i(flt[3]), .card_gone_i(flt[4]), .supply_low_i(supply_low),
    .card_rst_o(rst_o), .card_clk_en_o(clk_en), .card_io_en_o(io_en),
    .card_vcc_en_o(vcc_en), .deact_busy_o(busy), .deact_done_o(done),
    .flt_cause_o(cause)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int code, input longint c, input string req);
    ev_t e;
    e.code = code; e.cyc = c; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_act(input longint t);
    push(EV_DONE_F, t + 1, "R2");
    push(EV_VCC_R,  t + 1, "R2");
    push(EV_IO_R,   t + 1, "R2");
    push(EV_CLK_R,  t + 1, "R2");
    push(EV_RST_R,  t + 1, "R2");
  endtask

  task automatic push_deact(input longint t, input bit sl);
    longint b = t + 1;
    longint v = b + T1 + T2 + T3 + T4;
    push(EV_BUSY_R, b, "R3");
    push(EV_RST_F,  b + T1, "R4");
    push(EV_CLK_F,  b + T1 + T2, "R4");
    push(EV_IO_F,   b + T1 + T2 + T3, "R4");
    push(EV_VCC_F,  v, "R4");
    push(EV_BUSY_F, sl ? v + 1 : v + DIS, "R7");
    push(EV_DONE_R, sl ? v + 1 : v + DIS, "R7");
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, req, "pending events", exp_q.size(), 0);
    exp_q.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic monitor();
    logic [5:0] p, c;
    logic [11:0] ev;
    p = {done, busy, vcc_en, io_en, clk_en, rst_o};
    forever begin
      @(negedge clk);
      c = {done, busy, vcc_en, io_en, clk_en, rst_o};
      ev[EV_DONE_F] = p[5] & ~c[5];
      ev[EV_VCC_R]  = ~p[3] & c[3];
      ev[EV_IO_R]   = ~p[2] & c[2];
      ev[EV_CLK_R]  = ~p[1] & c[1];
      ev[EV_RST_R]  = ~p[0] & c[0];
      ev[EV_BUSY_R] = ~p[4] & c[4];
      ev[EV_RST_F]  = p[0] & ~c[0];
      ev[EV_CLK_F]  = p[1] & ~c[1];
      ev[EV_IO_F]   = p[2] & ~c[2];
      ev[EV_VCC_F]  = p[3] & ~c[3];
      ev[EV_BUSY_F] = p[4] & ~c[4];
      ev[EV_DONE_R] = ~p[5] & c[5];
      for (int k = 0; k < 12; k++) begin
        if (ev[k]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4/R6", "unexpected event code", k, -1);
          end else begin
            ev_t e = exp_q.pop_front();
            chk(e.code == k, e.req, "event code", k, e.code);
            chk(e.cyc == cyc, e.req, "event cycle", cyc, e.cyc);
          end
        end
      end
      p = c;
    end
  endtask

  task automatic watchdog();
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic activate();
    @(negedge clk); cmd = 1'b1;
    @(negedge clk);
    @(negedge clk); cmd = 1'b0;
    push_act(cyc);
    drain("R2");
    chk(vcc_en && io_en && clk_en && rst_o, "R2", "all enables high",
        {vcc_en, io_en, clk_en, rst_o}, 4'hf);
    chk(cause == 5'd0, "R5", "cause cleared on activation", cause, 0);
  endtask

  initial begin
    fork
      watchdog();
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({rst_o, clk_en, io_en, vcc_en, busy} == 5'b0, "R1", "enables/busy",
        {rst_o, clk_en, io_en, vcc_en, busy}, 0);
    chk(done == 1'b1, "R1", "done", done, 1);
    chk(cause == 5'd0, "R1", "cause", cause, 0);
    fork
      monitor();
    join_none
    // R8: command low since reset, no activation
    repeat (5) @(negedge clk);
    chk(vcc_en == 1'b0, "R8", "no activation without command high", vcc_en, 0);

    activate();

    // host-command shutdown, command held
    @(negedge clk); cmd = 1'b1;
    push_deact(cyc, 1'b1);
    drain("R4");
    chk(cause == 5'd0, "R5", "host shutdown cause", cause, 0);

    // each fault source, one-cycle pulse
    for (int k = 0; k < 5; k++) begin
      activate();
      @(negedge clk); flt[k] = 1'b1;
      push_deact(cyc, 1'b1);
      @(negedge clk); flt[k] = 1'b0;
      drain("R3");
      chk(cause == 5'(1 << k), "R5", "fault cause bit", cause, 1 << k);
      chk(done && !busy, "R7", "done after fault shutdown", {done, busy}, 2);
    end

    // R6: command pulse, withdrawn at once
    activate();
    @(negedge clk); cmd = 1'b1;
    push_deact(cyc, 1'b1);
    @(negedge clk); cmd = 1'b0;
    drain("R6");
    chk(done && !vcc_en, "R6", "completed after withdrawn trigger", {done, vcc_en}, 2);

    // R9: host command and over-temperature in the same cycle
    activate();
    @(negedge clk); cmd = 1'b1; flt[1] = 1'b1;
    push_deact(cyc, 1'b1);
    @(negedge clk); flt[1] = 1'b0;
    drain("R9");
    chk(cause == 5'b00010, "R9", "same-cycle cause", cause, 2);

    // R6/R5: fault arriving mid-sequence
    activate();
    @(negedge clk); cmd = 1'b1;
    push_deact(cyc, 1'b1);
    repeat (4) @(negedge clk);
    flt[0] = 1'b1;
    @(negedge clk); flt[0] = 1'b0;
    drain("R6");
    chk(cause == 5'd0, "R5", "late fault not recorded", cause, 0);

    // R8: no re-arm after fault shutdown with command low
    activate();
    @(negedge clk); flt[2] = 1'b1;
    push_deact(cyc, 1'b1);
    @(negedge clk); flt[2] = 1'b0;
    drain("R3");
    repeat (8) @(negedge clk);
    chk(vcc_en == 1'b0 && done, "R8", "held off until command high", vcc_en, 0);
    flt[1] = 1'b1;
    @(negedge clk); cmd = 1'b1;
    repeat (2) @(negedge clk);
    cmd = 1'b0;
    repeat (5) @(negedge clk);
    chk(vcc_en == 1'b0, "R8", "held off while fault high", vcc_en, 0);
    flt[1] = 1'b0;
    push_act(cyc);
    drain("R2");
    chk(vcc_en == 1'b1, "R8", "activates once fault clears", vcc_en, 1);

    // R7: discharge timeout, supply never reported low
    sl_en = 1'b0;
    @(negedge clk); cmd = 1'b1;
    push_deact(cyc, 1'b0);
    drain("R7");
    chk(done && !busy, "R7", "done after timeout", {done, busy}, 2);
    sl_en = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule